// File: doc/BRIEF.md
# Four-Way Event Counter Bank with Shared Freeze

The block holds four event counters that are run as one unit. Each counter picks one line of an input event vector through its own 8-bit source selector. A single configuration register holds the four selectors, one shared enable and one shared clear, so every counter covers the same interval of time. Software reads and writes the configuration register and the four counter values through a simple single-cycle register port.

Each counter is 40 bits wide and has a 41st bit that records an overflow. When any counter reaches its 40-bit maximum while the bank is enabled, the bank stops all four counters and raises a level interrupt. The stop takes one cycle to act. In that cycle a counter that sits at its maximum can still take one more event and roll into the overflow bit. A write of the clear bit zeroes every counter and drops the interrupt. Software may also load any counter directly, and counting then goes on from the loaded value.

Register addresses: 0 is the configuration register. Addresses 1 to 4 are counters 0 to 3. The other addresses read as zero.

Top module: `evt_ctr_bank`

## Requirements
- R1: The configuration register keeps the selectors of counters 0, 1, 2 and 3 in bits 7:0, 15:8, 23:16 and 31:24. The enable is bit 32 and the clear is bit 33. A read of address 0 returns the selectors and the enable, and bit 33 always reads 0.
- R2: While enabled, a counter adds one on each clock whose selected event line is high. A selector value equal to or greater than the number of event lines counts nothing.
- R3: A configuration write with bit 33 set zeroes all four counters at that clock edge and deasserts the interrupt.
- R4: When one write sets both bit 32 and bit 33, the counters read zero after the write and begin counting on the following clock.
- R5: When any counter holds 0xFF_FFFF_FFFF while the bank is enabled, the next clock edge clears the enable and asserts the interrupt, and all four counters stop together.
- R6: In that one lag cycle a counter at the maximum whose event is high steps to 0x100_0000_0000, with bit 40 as the overflow bit.
- R7: A write to a counter address loads bits 40:0 of the write data. If the bank is enabled, counting continues from the loaded value.
- R8: If a counter write and an increment of the same counter fall in the same cycle, the written value is kept.
- R9: The interrupt is a level. It stays high until bit 33 is written, even if the enable is set again without a clear.
- R10: While the bank is disabled the counters hold their values.
- R11: If a configuration write that sets the enable without the clear lands in the same cycle as a saturation stop, the stop wins: the enable reads 0 afterwards and the interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Register address (0 configuration, 1 to 4 counters) |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_addr, combinational |
| evt_i | input | NUM_EVT | Event lines the selectors choose from |
| irq_o | output | 1 | Level interrupt, raised on saturation |

## Verification
Two pairs of functions can fall in one cycle. The first pair is a software load of a counter and that counter's own increment. The bench provokes it by writing a counter while the bank runs with its event held high, and judges it by reading the exact written value once and then that value plus one on the next clock. The second pair is the saturation stop and a configuration write that sets the enable. The bench loads a counter one below the maximum, enables it, and times an enable write onto the cycle in which the counter holds the maximum. It then expects the enable to read 0, the interrupt to be high and the counter to freeze at the overflow value.

// File: rtl/evb_pkg.sv
// Package evb_pkg
// Shared constants and address map for the event counter bank.
// Assumes a 64-bit register port and at most 32 bits of selector fields.
package evb_pkg;

    localparam int NUM_CTR = 4;     // counters in the bank
    localparam int SEL_W   = 8;     // width of one source selector
    localparam int ADDR_W  = 3;     // register address width
    localparam int DATA_W  = 64;    // register data width
    localparam int EN_BIT  = 32;    // shared enable position
    localparam int CLR_BIT = 33;    // shared clear position (write-only)

    typedef enum logic [ADDR_W-1:0] {
        ADR_CFG  = 3'd0,
        ADR_CNT0 = 3'd1,
        ADR_CNT1 = 3'd2,
        ADR_CNT2 = 3'd3,
        ADR_CNT3 = 3'd4
    } evb_addr_e;

endpackage

// File: rtl/evb_src_mux.sv
// Module evb_src_mux
// Picks one event line by selector value. If the selector is equal to or
// greater than NUM_EVT, the output is held low.
// Assumes NUM_EVT <= 2**SEL_W.
module evb_src_mux #(
    parameter int NUM_EVT = 16,
    parameter int SEL_W   = 8
) (
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic               hit_o
);

    // Purpose: decode the selector against every event line.
    always_comb begin
        hit_o = 1'b0;
        for (int i = 0; i < NUM_EVT; i++) begin
            if (int'(sel_i) == i) hit_o = evt_i[i];
        end
    end

endmodule

// File: rtl/evb_counter.sv
// Module evb_counter
// One counter with overflow: CNT_W count bits plus one overflow bit.
// Priority: clear, then load, then increment. Reports when it is at or
// past the CNT_W-bit maximum.
// Assumes the caller gates inc_i with the bank enable.
module evb_counter #(
    parameter int CNT_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             ld_i,
    input  logic [CNT_W:0]   ld_val_i,
    input  logic             inc_i,
    output logic [CNT_W:0]   val_o,
    output logic             at_max_o
);

    localparam int VAL_W = CNT_W + 1;

    logic [VAL_W-1:0] val_q;

    // Purpose: counter register with clear, load and increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
        end else if (clr_i) begin
            val_q <= '0;
        end else if (ld_i) begin
            val_q <= ld_val_i;
        end else if (inc_i) begin
            val_q <= val_q + VAL_W'(1);
        end
    end

    // Purpose: flag the maximum or any overflowed value.
    assign at_max_o = val_q[CNT_W] | (&val_q[CNT_W-1:0]);
    assign val_o    = val_q;

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !ld_i && !clr_i && !val_q[CNT_W]) |=> (val_q == $past(val_q) + VAL_W'(1))); // R2
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_i && !clr_i) |=> (val_q == $past(ld_val_i))); // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && !ld_i && !clr_i) |=> $stable(val_q)); // R10
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (val_q == '0)); // R3

endmodule

// File: rtl/evb_ctrl.sv
// Module evb_ctrl
// Holds the configuration register (selectors and shared enable) and the
// interrupt. A saturation stop clears the enable. A clear write overrides
// everything and drops the interrupt.
// Assumes sat_any_i comes straight from the counters' current values.
module evb_ctrl
    import evb_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_wr_i,
    input  logic [CLR_BIT:0]              wdata_i,
    input  logic                          sat_any_i,
    output logic                          en_o,
    output logic                          irq_o,
    output logic                          clr_o,
    output logic [NUM_CTR-1:0][SEL_W-1:0] sel_o,
    output logic [DATA_W-1:0]             cfg_rd_o
);

    localparam int SELS_W = NUM_CTR * SEL_W;

    logic                          en_q;
    logic                          irq_q;
    logic [NUM_CTR-1:0][SEL_W-1:0] sel_q;
    logic                          stop;

    assign clr_o = cfg_wr_i & wdata_i[CLR_BIT];
    assign stop  = en_q & sat_any_i;

    // Purpose: selector fields, written by any configuration write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (cfg_wr_i) begin
            sel_q <= wdata_i[SELS_W-1:0];
        end
    end

    // Purpose: shared enable; clear write first, then the saturation stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (clr_o) begin
            en_q <= wdata_i[EN_BIT];
        end else if (stop) begin
            en_q <= 1'b0;
        end else if (cfg_wr_i) begin
            en_q <= wdata_i[EN_BIT];
        end
    end

    // Purpose: level interrupt, set by a stop and dropped only by a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (clr_o) begin
            irq_q <= 1'b0;
        end else if (stop) begin
            irq_q <= 1'b1;
        end
    end

    // Purpose: read view; the clear bit always reads zero.
    always_comb begin
        cfg_rd_o                 = '0;
        cfg_rd_o[SELS_W-1:0]     = sel_q;
        cfg_rd_o[EN_BIT]         = en_q;
    end

    assign en_o  = en_q;
    assign irq_o = irq_q;
    assign sel_o = sel_q;

    AST_STOP_ACTS: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && sat_any_i && !clr_o) |=> (!en_q && irq_q)); // R5
    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !clr_o) |=> irq_q); // R9
    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o |=> !irq_q); // R3
    AST_BOTH_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_o && wdata_i[EN_BIT]) |=> en_q); // R4

endmodule

// File: rtl/evt_ctr_bank.sv
// Module evt_ctr_bank
// Top of the four-counter bank: per-counter source muxes and counters,
// shared control, and the register read mux.
// Assumes CNT_W + 1 < DATA_W and NUM_EVT <= 256.
module evt_ctr_bank
    import evb_pkg::*;
#(
    parameter int NUM_EVT = 16,
    parameter int CNT_W   = 40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [2:0]           reg_addr,
    input  logic [63:0]          reg_wdata,
    output logic [63:0]          reg_rdata,
    input  logic [NUM_EVT-1:0]   evt_i,
    output logic                 irq_o
);

    localparam int VAL_W = CNT_W + 1;

    logic                          en;
    logic                          clr;
    logic                          cfg_wr;
    logic                          sat_any;
    logic [NUM_CTR-1:0][SEL_W-1:0] sel;
    logic [NUM_CTR-1:0]            hit;
    logic [NUM_CTR-1:0]            at_max;
    logic [NUM_CTR-1:0]            ld;
    logic [VAL_W-1:0]              cnt_val [NUM_CTR];
    logic [DATA_W-1:0]             cfg_rd;
    logic                          unused_wdata_hi;

    assign cfg_wr          = reg_wr & (reg_addr == ADR_CFG);
    assign sat_any         = |at_max;
    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:VAL_W];

    evb_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr_i  (cfg_wr),
        .wdata_i   (reg_wdata[CLR_BIT:0]),
        .sat_any_i (sat_any),
        .en_o      (en),
        .irq_o     (irq_o),
        .clr_o     (clr),
        .sel_o     (sel),
        .cfg_rd_o  (cfg_rd)
    );

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        assign ld[g] = reg_wr & (reg_addr == ADDR_W'(g + 1));

        evb_src_mux #(
            .NUM_EVT (NUM_EVT),
            .SEL_W   (SEL_W)
        ) u_mux (
            .evt_i (evt_i),
            .sel_i (sel[g]),
            .hit_o (hit[g])
        );

        evb_counter #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr_i    (clr),
            .ld_i     (ld[g]),
            .ld_val_i (reg_wdata[VAL_W-1:0]),
            .inc_i    (en & hit[g]),
            .val_o    (cnt_val[g]),
            .at_max_o (at_max[g])
        );
    end

    // Purpose: register read mux; unmapped addresses read zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADR_CFG) reg_rdata = cfg_rd;
        for (int i = 0; i < NUM_CTR; i++) begin
            if (reg_addr == ADDR_W'(i + 1)) reg_rdata = DATA_W'(cnt_val[i]);
        end
    end

    AST_IRQ_WITH_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> !en); // R5
    AST_STOP_BEATS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (en && sat_any && cfg_wr && !reg_wdata[CLR_BIT]) |=> (!en && irq_o)); // R11
    AST_CLR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd[CLR_BIT] == 1'b0); // R1

endmodule

// File: tb/evt_ctr_bank_tb_top.sv
module evt_ctr_bank_tb_top;

    localparam int NUM_EVT = 16;
    localparam logic [63:0] CFG_EN  = 64'h1_0000_0000;
    localparam logic [63:0] CFG_CLR = 64'h2_0000_0000;
    localparam logic [63:0] MAXV    = 64'h00FF_FFFF_FFFF;
    localparam logic [63:0] OVFV    = 64'h0100_0000_0000;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               reg_wr;
    logic [2:0]         reg_addr;
    logic [63:0]        reg_wdata;
    logic [63:0]        reg_rdata;
    logic [NUM_EVT-1:0] evt;
    logic               irq;

    int checks   = 0;
    int failures = 0;

    evt_ctr_bank #(.NUM_EVT(NUM_EVT), .CNT_W(40)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt_i     (evt),
        .irq_o     (irq)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [63:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [63:0] d;
        rd(3'd0, d); chk("R1 reset cfg", d, 64'h0);
        rd(3'd1, d); chk("R10 reset cnt0", d, 64'h0);
        chk("R9 reset irq", {63'h0, irq}, 64'h0);
    endtask

    task automatic t_cfg();
        logic [63:0] d;
        wr(3'd0, CFG_CLR | 64'hA5C3_2A07);
        rd(3'd0, d); chk("R1 fields, clear reads 0", d, 64'h0000_0000_A5C3_2A07);
        wr(3'd0, 64'h0);
    endtask

    task automatic t_count();
        logic [63:0] d;
        wr(3'd1, 64'd100);
        evt = 16'hFFFD;
        wr(3'd0, CFG_EN | CFG_CLR | 64'h0040_0100);
        rd(3'd1, d); chk("R4 zero after enable+clear", d, 64'h0);
        repeat (5) @(negedge clk);
        wr(3'd0, 64'h0040_0100);
        rd(3'd1, d); chk("R2 cnt0 counts", d, 64'd7);
        rd(3'd2, d); chk("R2 cnt1 event low", d, 64'd0);
        rd(3'd3, d); chk("R2 out-of-range selector", d, 64'd0);
        rd(3'd4, d); chk("R2 cnt3 shared source", d, 64'd7);
        repeat (3) @(negedge clk);
        rd(3'd1, d); chk("R10 hold while disabled", d, 64'd7);
        wr(3'd0, CFG_EN | 64'h0040_0100);
        wr(3'd1, 64'd1000);
        rd(3'd1, d); chk("R8 write beats increment", d, 64'd1000);
        @(negedge clk);
        rd(3'd1, d); chk("R7 count from written value", d, 64'd1001);
        wr(3'd0, CFG_CLR);
        evt = '0;
    endtask

    task automatic t_sat();
        logic [63:0] d;
        wr(3'd0, 64'h0000_0200);
        wr(3'd1, MAXV - 64'd2);
        wr(3'd2, 64'd5);
        evt = 16'h0005;
        wr(3'd0, CFG_EN | 64'h0000_0200);
        repeat (4) @(negedge clk);
        rd(3'd1, d); chk("R6 lag count sets bit 40", d, OVFV);
        rd(3'd2, d); chk("R5 other counter frozen", d, 64'd8);
        rd(3'd0, d); chk("R5 enable cleared", d, 64'h0000_0200);
        chk("R5 irq raised", {63'h0, irq}, 64'h1);
        evt = '0;
        wr(3'd0, CFG_EN | 64'h0000_0200);
        repeat (3) @(negedge clk);
        chk("R9 irq stays after re-enable", {63'h0, irq}, 64'h1);
        rd(3'd1, d); chk("R9 counter unchanged", d, OVFV);
        wr(3'd0, CFG_CLR);
        chk("R3 clear drops irq", {63'h0, irq}, 64'h0);
        rd(3'd1, d); chk("R3 clear zeroes cnt0", d, 64'h0);
        rd(3'd2, d); chk("R3 clear zeroes cnt1", d, 64'h0);
    endtask

    task automatic t_collide();
        logic [63:0] d;
        wr(3'd0, 64'h0);
        wr(3'd1, MAXV - 64'd1);
        evt = 16'h0001;
        wr(3'd0, CFG_EN);
        wr(3'd0, CFG_EN);
        rd(3'd0, d); chk("R11 stop beats enable write", d, 64'h0);
        chk("R11 irq raised", {63'h0, irq}, 64'h1);
        repeat (2) @(negedge clk);
        rd(3'd1, d); chk("R11 counter frozen at overflow", d, OVFV);
        evt = '0;
        wr(3'd0, CFG_CLR);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        reg_wr    = 1'b0;
        reg_addr  = 3'd0;
        reg_wdata = '0;
        evt       = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cfg();
        t_count();
        t_sat();
        t_collide();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule